// File: doc/BRIEF.md
# Two-Step Counter/Vernier Interval Combiner

This block measures the time from a clock-aligned start to an asynchronous stop and reports it as a 10-bit code. A coarse counter counts reference-clock rising edges while its enable is high. The enable goes high on the start and drops as soon as the stop edge arrives. The block then drives the two markers that bound the fine window. The fine-window start follows the stop level combinationally. The fine-window stop is a one-cycle flag raised by the first clock rising edge after the stop.

An external Vernier line measures the fine window and returns a 16-tap thermometer word. The block counts the leading ones of that word and repairs a broken pattern. It then forms the result as sixteen times the coarse count minus the fine residue, clamped to the 10-bit range. A one-cycle done strobe marks each new result, and the result is held until the next measurement completes.

Top module: `tdc_two_step`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, cnt_en_o, fine_start_o, fine_stop_o, done_o, code_o and therm_err_o are all 0.
- R2: A measurement begins at a rising clock edge that samples start_i high when it was low at the previous edge and the block is idle. cnt_en_o is high from that point until stop_i rises. M is the number of rising edges at which cnt_en_o is high, including the launching edge. M saturates at 127.
- R3: While a measurement is running, fine_start_o follows stop_i combinationally. fine_stop_o is high for exactly the one cycle after the first rising edge that sees stop_i high. If start_i and stop_i are both high at the launching edge, M is 0.
- R4: The fine count L is the number of consecutive ones in therm_i counted from bit 0 upward. A value of 16 is reported as 15. therm_i is sampled at the rising edge that ends the fine_stop_o cycle.
- R5: code_o = 16·M − L. A negative result is reported as 0, and a result above 1023 is reported as 1023.
- R6: If therm_i holds a 1 at some bit i with a 0 at bit i−1, therm_err_o is 1 for that result, and L still counts only the leading ones. Otherwise therm_err_o is 0.
- R7: done_o is high for exactly one cycle, the cycle after fine_stop_o. code_o and therm_err_o take their new values at the same edge.
- R8: code_o changes only at the edge where done_o rises. While idle, stop_i has no effect on cnt_en_o, fine_start_o, done_o or code_o.
- R9: A new rise of start_i during a running measurement is ignored: the measurement is neither restarted nor cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start_i | input | 1 | Start level, clock-aligned |
| stop_i | input | 1 | Stop level from the comparator, asynchronous |
| therm_i | input | 16 | Thermometer word from the Vernier line, bit 0 first |
| cnt_en_o | output | 1 | Coarse count enable |
| fine_start_o | output | 1 | Fine-window start marker |
| fine_stop_o | output | 1 | Fine-window stop marker |
| done_o | output | 1 | One-cycle result strobe |
| code_o | output | 10 | Combined interval code |
| therm_err_o | output | 1 | Thermometer word was not monotonic |

## Verification
A wrong count or a missed stop shows on code_o, with an error of 16 per counting slip, two cycles after the stop edge. A wrong phase in the control state shows even earlier: fine_start_o or cnt_en_o goes wrong within the same cycle as the stop, or fine_stop_o and done_o appear in the wrong cycle. A faulty thermometer decode shows as an error of 1 to 15 in the low bits of code_o, or as a wrong therm_err_o, in the done cycle. A broken hold shows as code_o moving in a cycle where done_o is low.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_FINE  = 2'd2
  } tdc_phase_e;

  localparam int unsigned DEF_COARSE_W = 6;
  localparam int unsigned DEF_FINE_W   = 4;
  localparam int unsigned DEF_TAPS     = 16;
endpackage

// File: rtl/tdc_coarse_ctl.sv
`timescale 1ns/1ps
module tdc_coarse_ctl
  import tdc_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             cnt_en_o,
  output logic             fine_start_o,
  output logic             fine_stop_o,
  output logic [CNT_W-1:0] coarse_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  tdc_phase_e      phase_q, phase_d;
  logic            start_q;
  logic [CNT_W-1:0] cnt_q;
  logic            launch;
  logic            active;

  // A new start is accepted only from idle (R2, R9)
  assign launch       = start_i & ~start_q & (phase_q == PH_IDLE);
  assign active       = launch | (phase_q == PH_COUNT);
  assign cnt_en_o     = active & ~stop_i;
  assign fine_start_o = active & stop_i;
  assign fine_stop_o  = (phase_q == PH_FINE);
  assign coarse_o     = cnt_q;

  always_comb begin
    phase_d = phase_q;
    if (active && stop_i)   phase_d = PH_FINE;
    else if (active)        phase_d = PH_COUNT;
    else if (phase_q == PH_FINE) phase_d = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      start_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      start_q <= start_i;
      if (launch)
        cnt_q <= {{(CNT_W-1){1'b0}}, ~stop_i};
      else if (cnt_en_o && cnt_q != CNT_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: the fine-window stop marker lasts one cycle
  p_fine_stop_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fine_stop_o |=> !fine_stop_o);

  // R2: the counter steps by one per enabled edge while counting
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_COUNT && !stop_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2: a saturated counter never wraps during a measurement
  p_count_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_COUNT && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/tdc_therm_dec.sv
`timescale 1ns/1ps
module tdc_therm_dec #(
  parameter int unsigned TAPS   = 16,
  parameter int unsigned FINE_W = 4
) (
  input  logic [TAPS-1:0]   therm_i,
  output logic [FINE_W-1:0] fine_o,
  output logic              err_o
);
  localparam int unsigned OW = $clog2(TAPS + 1);
  localparam logic [OW-1:0] FINE_MAX = OW'((1 << FINE_W) - 1);

  logic [TAPS-1:0] up_step;
  logic [OW-1:0]   raw_ones;

  // Count of ones before the first zero, starting at bit 0
  function automatic logic [OW-1:0] lead_ones(input logic [TAPS-1:0] t);
    logic          run;
    logic [OW-1:0] n;
    run = 1'b1;
    n   = '0;
    for (int i = 0; i < TAPS; i++) begin
      run = run & t[i];
      n   = n + OW'(run);
    end
    return n;
  endfunction

  function automatic logic [FINE_W-1:0] clip_fine(input logic [OW-1:0] n);
    return (n > FINE_MAX) ? FINE_MAX[FINE_W-1:0] : n[FINE_W-1:0];
  endfunction

  // A zero-to-one step between neighbours marks a broken pattern (R6)
  assign up_step[0] = 1'b0;
  for (genvar g = 1; g < TAPS; g++) begin : g_step
    assign up_step[g] = therm_i[g] & ~therm_i[g-1];
  end

  assign err_o    = |up_step;
  assign raw_ones = lead_ones(therm_i);
  assign fine_o   = clip_fine(raw_ones);

  // R4: a clean word is counted in full
  always_comb begin
    a_clean_count_r4: assert (err_o || raw_ones == OW'($countones(therm_i)));
  end
endmodule

// File: rtl/tdc_combine.sv
`timescale 1ns/1ps
module tdc_combine #(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned FINE_W = 4,
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fine_stop_i,
  input  logic [CNT_W-1:0]  coarse_i,
  input  logic [FINE_W-1:0] fine_i,
  input  logic              err_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o,
  output logic              therm_err_o
);
  localparam int unsigned PW = CNT_W + FINE_W;
  localparam logic [PW-1:0] CODE_MAX = PW'((1 << CODE_W) - 1);

  // Coarse weight minus fine residue, clamped to the code range (R5)
  function automatic logic [CODE_W-1:0] join_code(input logic [CNT_W-1:0] m,
                                                   input logic [FINE_W-1:0] l);
    logic [PW-1:0] pos;
    logic [PW-1:0] res;
    logic [PW-1:0] diff;
    pos  = {m, {FINE_W{1'b0}}};
    res  = {{CNT_W{1'b0}}, l};
    diff = pos - res;
    if (pos < res)            return '0;
    else if (diff > CODE_MAX) return CODE_MAX[CODE_W-1:0];
    else                      return diff[CODE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      code_o      <= '0;
      therm_err_o <= 1'b0;
    end else begin
      done_o <= fine_stop_i;
      if (fine_stop_i) begin
        code_o      <= join_code(coarse_i, fine_i);
        therm_err_o <= err_i;
      end
    end
  end

  // R7: done follows the fine-window stop by one cycle
  p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fine_stop_i |=> done_o);

  // R7: done is a single-cycle strobe
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: the code holds outside the done cycle
  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o));

  // R5: a zero coarse count clamps to zero
  p_neg_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_stop_i && coarse_i == '0) |=> (code_o == '0));
endmodule

// File: rtl/tdc_two_step.sv
`timescale 1ns/1ps
module tdc_two_step
  import tdc_pkg::*;
#(
  parameter int unsigned COARSE_W = DEF_COARSE_W,
  parameter int unsigned FINE_W   = DEF_FINE_W,
  parameter int unsigned TAPS     = DEF_TAPS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         stop_i,
  input  logic [TAPS-1:0]              therm_i,
  output logic                         cnt_en_o,
  output logic                         fine_start_o,
  output logic                         fine_stop_o,
  output logic                         done_o,
  output logic [COARSE_W+FINE_W-1:0]   code_o,
  output logic                         therm_err_o
);
  localparam int unsigned CNT_W  = COARSE_W + 1;
  localparam int unsigned CODE_W = COARSE_W + FINE_W;

  logic [CNT_W-1:0]  coarse_w;
  logic [FINE_W-1:0] fine_w;
  logic              dec_err_w;

  tdc_coarse_ctl #(.CNT_W(CNT_W)) i_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .cnt_en_o     (cnt_en_o),
    .fine_start_o (fine_start_o),
    .fine_stop_o  (fine_stop_o),
    .coarse_o     (coarse_w)
  );

  tdc_therm_dec #(.TAPS(TAPS), .FINE_W(FINE_W)) i_dec (
    .therm_i (therm_i),
    .fine_o  (fine_w),
    .err_o   (dec_err_w)
  );

  tdc_combine #(.CNT_W(CNT_W), .FINE_W(FINE_W), .CODE_W(CODE_W)) i_comb (
    .clk         (clk),
    .rst_n       (rst_n),
    .fine_stop_i (fine_stop_o),
    .coarse_i    (coarse_w),
    .fine_i      (fine_w),
    .err_i       (dec_err_w),
    .done_o      (done_o),
    .code_o      (code_o),
    .therm_err_o (therm_err_o)
  );
endmodule

// File: tb/test_tdc_two_step.sv
`timescale 1ns/100ps
module test_tdc_two_step;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [15:0] therm_i = 16'h0000;
  logic        cnt_en_o, fine_start_o, fine_stop_o, done_o, therm_err_o;
  logic [9:0]  code_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tdc_two_step i_tdc_two_step (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .therm_i(therm_i), .cnt_en_o(cnt_en_o), .fine_start_o(fine_start_o),
    .fine_stop_o(fine_stop_o), .done_o(done_o), .code_o(code_o),
    .therm_err_o(therm_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lead(input logic [15:0] t);
    int n = 0;
    while (n < 16 && t[n]) n++;
    return (n > 15) ? 15 : n;
  endfunction

  function automatic int expect_code(input int k, input logic [15:0] t);
    int m = (k > 127) ? 127 : k;
    int v = m * 16 - lead(t);
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  function automatic int broken(input logic [15:0] t);
    for (int i = 1; i < 16; i++) if (t[i] && !t[i-1]) return 1;
    return 0;
  endfunction

  // One measurement with k enabled edges; glitch re-raises start mid-count (R9)
  task automatic run(input int k, input logic [15:0] th, input bit glitch);
    int ec = expect_code(k, th);
    @(negedge clk);
    therm_i = th;
    if (k == 0) begin
      start_i = 1'b1; stop_i = 1'b1;
      #0.2;
      chk("R3 fine start with stop at launch", fine_start_o, 1);
      chk("R2 no enable when stop at launch", cnt_en_o, 0);
    end else begin
      start_i = 1'b1;
      #0.2;
      chk("R2 enable after start", cnt_en_o, 1);
      for (int c = 0; c < k; c++) begin
        @(posedge clk);
        if (glitch && c == 1) begin #1 start_i = 1'b0; end
        if (glitch && c == 2) begin #1 start_i = 1'b1; end
      end
      @(negedge clk);
      #0.5 stop_i = 1'b1;
      #0.2;
      chk("R3 fine start follows stop", fine_start_o, 1);
      chk("R2 enable drops on stop", cnt_en_o, 0);
    end
    @(posedge clk); #1;
    chk("R3 fine stop marker", fine_stop_o, 1);
    chk("R7 no done with marker", done_o, 0);
    @(posedge clk); #1;
    chk("R7 done strobe", done_o, 1);
    chk("R3 marker one cycle", fine_stop_o, 0);
    chk(glitch ? "R9 restart ignored code" : "R5 code", code_o, ec);
    chk("R6 error flag", therm_err_o, broken(th));
    @(posedge clk); #1;
    chk("R7 done one cycle", done_o, 0);
    chk("R8 code held", code_o, ec);
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  initial begin
    #760000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 code in reset", code_o, 0);
    chk("R1 done in reset", done_o, 0);
    chk("R1 enable in reset", cnt_en_o, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 fine stop after reset", fine_stop_o, 0);
    chk("R1 error flag after reset", therm_err_o, 0);

    // Coarse sweep, including counter saturation and code clamping (R2, R5)
    for (int k = 0; k < 70; k++) run(k, 16'((32'h1 << ((k * 7) % 17)) - 1), 1'b0);
    run(130, 16'h0003, 1'b0);
    run(64, 16'h0000, 1'b0);

    // Every fine count near zero coarse weight (R4, R5)
    for (int l = 0; l <= 16; l++) run(1, 16'((32'h1 << l) - 1), 1'b0);
    for (int l = 0; l <= 16; l++) run(0, 16'((32'h1 << l) - 1), 1'b0);

    // Broken thermometer words (R6)
    for (int l = 0; l < 15; l++)
      for (int j = l + 1; j < 16; j += 3)
        run(9, 16'((32'h1 << l) - 1) | 16'(32'h1 << j), 1'b0);

    // Start re-raised during counting (R9)
    run(6, 16'h001F, 1'b1);
    run(20, 16'h0000, 1'b1);

    // Idle stop has no effect (R8)
    held = int'(code_o);
    @(negedge clk); stop_i = 1'b1; #0.2;
    chk("R8 idle stop no fine start", fine_start_o, 0);
    chk("R8 idle stop no enable", cnt_en_o, 0);
    repeat (3) begin
      @(posedge clk); #1;
      chk("R8 idle stop no done", done_o, 0);
      chk("R8 idle stop no marker", fine_stop_o, 0);
      chk("R8 idle code held", code_o, held);
    end
    @(negedge clk); stop_i = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule